// File: doc/BRIEF.md
# Low-Power Timer and Pulse Counter

This block is a 16-bit up-counter with a small memory-mapped register set. In time mode it counts ticks taken from one of four clock-enable sources, either directly or through a power-of-two prescaler. In pulse mode it counts active edges on one of four external inputs. Each input has a selectable polarity and can pass through a glitch filter that samples on the chosen clock-enable source. All clock sources are modelled as enables inside a single system clock domain.

When a counted tick arrives while the counter equals the compare value, the block does three things: it sets a sticky compare flag, emits a one-cycle trigger pulse and raises an interrupt if interrupts are enabled. The counter then either restarts from zero or, in free-run mode, keeps counting and wraps after 0xFFFF. Software clears the flag by writing a one to it. To read the live count, software first writes the snapshot register, which latches the count, and then reads the latched value.

Register map (byte offsets):
- 0x0 control/status: bit0 run, bit1 mode (0 time, 1 pulse), bit2 free-run, bit3 polarity (1 = active-low), bits5:4 input select, bit6 interrupt enable, bit7 compare flag.
- 0x4 tick setup: bits1:0 source select, bit2 bypass, bits6:3 code.
- 0x8 compare.
- 0xC count snapshot.

Top module: `ltpc_top`

## Requirements
- R1: In time mode with bypass set, the count rises by one for each clock cycle in which the selected source enable is high, and holds otherwise.
- R2: In pulse mode with bypass set, the count rises by one on each transition of the selected input (bits5:4) into its active level, where bit3=0 means active-high and bit3=1 means active-low; other inputs have no effect.
- R3: In time mode with bypass clear, one tick is counted per 2^(code+1) source enables, with code in bits6:3 of offset 0x4.
- R4: Only the source chosen by bits1:0 of offset 0x4 advances the prescaler, the filter or the bypassed tick path.
- R5: In pulse mode with bypass clear, an input change is accepted only after 2^code consecutive matching samples taken on source enables; code 0 is treated as code 1 (two samples).
- R6: A tick that arrives while count equals compare sets the flag (bit7) and gives a one-cycle pulse on trig_o in the same cycle; with free-run off the count then returns to 0.
- R7: With free-run on (bit2), the count passes the compare value and wraps from 0xFFFF to 0.
- R8: Writing 1 to bit7 of offset 0x0 clears the flag and writing 0 leaves it; irq_o is high exactly while the flag and the interrupt enable (bit6) are both set.
- R9: A write of any value to offset 0xC latches the live count; reads of 0xC return the latched value until the next such write.
- R10: While run (bit0) is 0, the count, the flag and the prescaler and filter state are held at zero.
- R11: While run is 1, writes to mode, polarity and input select at offset 0x0 and all writes to offset 0x4 are ignored; interrupt enable and free-run remain writable.
- R12: After reset the registers read 0x00 at 0x0, 0x05 at 0x4 (source 1, bypass on, code 0), and 0 at 0x8 and 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_en | input | 4 | Clock-enable sources, one per select value |
| pin_in | input | 4 | External pulse inputs |
| trig_o | output | 1 | One-cycle pulse on compare match |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 16-bit count, a 4-bit code and 2-bit selects. With these values a free-running wrap past 0xFFFF fits within about 65 thousand ticks, so the bench can exercise it directly. Random prescale codes are kept at 4 or below, which means each random trial contains several full divide periods. The filter is tested at codes 0 and 2, where both the accepted glitch length and the rejected one take only a few samples.

// File: rtl/ltpc_pkg.sv
// Package: shared widths, register offsets and register layouts for the
// low-power timer / pulse counter. Assumes byte offsets on a 4-bit address.
package ltpc_pkg;
    parameter int SEL_W  = 2;
    parameter int CODE_W = 4;
    parameter int CNT_W  = 16;

    localparam logic [3:0] OFS_CSR  = 4'h0;
    localparam logic [3:0] OFS_PRE  = 4'h4;
    localparam logic [3:0] OFS_CMP  = 4'h8;
    localparam logic [3:0] OFS_SNAP = 4'hC;

    // control/status layout, LSB = run; flag sits just above ie
    typedef struct packed {
        logic             ie;
        logic [SEL_W-1:0] pin;
        logic             pol;
        logic             freerun;
        logic             mode;
        logic             en;
    } ctrl_t;

    // tick setup layout, LSB = source select
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              bypass;
        logic [SEL_W-1:0]  clksel;
    } pre_t;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int PRE_BITS  = $bits(pre_t);
    localparam pre_t PRE_RST = '{code: '0, bypass: 1'b1, clksel: SEL_W'(1)};
endpackage

// File: rtl/ltpc_regs.sv
// Register file: control/status, tick setup, compare, snapshot and the
// write-one-to-clear compare flag. Assumes a single-cycle write strobe and
// a combinational read port. Setup fields are locked while running.
module ltpc_regs
    import ltpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hit,
    input  logic [CW-1:0]     cnt,
    output ctrl_t             ctrl,
    output pre_t              pre,
    output logic [CW-1:0]     cmp,
    output logic              flag,
    output logic [DATA_W-1:0] bus_rdata
);
    logic          wr_csr, wr_pre, wr_cmp, wr_snap;
    ctrl_t         ctrl_in;
    logic [CW-1:0] snap;
    logic          unused_wdata;

    assign wr_csr  = bus_wr && (bus_addr == ADDR_W'(OFS_CSR));
    assign wr_pre  = bus_wr && (bus_addr == ADDR_W'(OFS_PRE));
    assign wr_cmp  = bus_wr && (bus_addr == ADDR_W'(OFS_CMP));
    assign wr_snap = bus_wr && (bus_addr == ADDR_W'(OFS_SNAP));
    assign ctrl_in = ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
    assign unused_wdata = ^bus_wdata;

    // control: run, ie, free-run always writable; mode fields only when stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_csr) begin
            ctrl.en      <= ctrl_in.en;
            ctrl.ie      <= ctrl_in.ie;
            ctrl.freerun <= ctrl_in.freerun;
            if (!ctrl.en) begin
                ctrl.mode <= ctrl_in.mode;
                ctrl.pol  <= ctrl_in.pol;
                ctrl.pin  <= ctrl_in.pin;
            end
        end
    end

    // tick setup: accepted only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre <= PRE_RST;
        else if (wr_pre && !ctrl.en)
            pre <= pre_t'(bus_wdata[PRE_BITS-1:0]);
    end

    // compare value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp <= '0;
        else if (wr_cmp)
            cmp <= bus_wdata[CW-1:0];
    end

    // compare flag: cleared when stopped, set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl.en)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (wr_csr && bus_wdata[CTRL_BITS])
            flag <= 1'b0;
    end

    // snapshot: any write latches the live count
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (wr_snap)
            snap <= cnt;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CSR):  bus_rdata[CTRL_BITS:0] = {flag, ctrl};
            ADDR_W'(OFS_PRE):  bus_rdata[PRE_BITS-1:0] = pre;
            ADDR_W'(OFS_CMP):  bus_rdata[CW-1:0] = cmp;
            ADDR_W'(OFS_SNAP): bus_rdata[CW-1:0] = snap;
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ltpc_tick_gen.sv
// Tick generator: turns the selected clock-enable source or pulse input into
// a single-cycle count enable. Time mode uses a 2^(code+1) prescaler; pulse
// mode uses a 2^code-sample glitch filter (code 0 acts as 1). Assumes inputs
// are already synchronous to clk.
module ltpc_tick_gen
    import ltpc_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CWD = CODE_W,
    localparam int NSRC  = 1 << SW,
    localparam int PRE_W = 1 << CWD
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           mode,
    input  logic           pol,
    input  logic [SW-1:0]  pin,
    input  logic           bypass,
    input  logic [SW-1:0]  clksel,
    input  logic [CWD-1:0] code,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] pin_in,
    output logic           tick
);
    logic             src, raw, raw_q, filt_lvl;
    logic [PRE_W-1:0] pre_cnt, filt_run, pre_lim, filt_lim;
    logic [PRE_W:0]   pre_full, filt_full;
    logic [CWD:0]     pre_sh, filt_sh;

    assign src = src_en[clksel];
    assign raw = pin_in[pin] ^ pol;

    // terminal values for the prescaler and the filter run length
    always_comb begin
        pre_sh    = {1'b0, code} + (CWD+1)'(1);
        filt_sh   = (code == '0) ? (CWD+1)'(1) : {1'b0, code};
        pre_full  = ((PRE_W+1)'(1) << pre_sh) - (PRE_W+1)'(1);
        filt_full = ((PRE_W+1)'(1) << filt_sh) - (PRE_W+1)'(1);
        pre_lim   = pre_full[PRE_W-1:0];
        filt_lim  = filt_full[PRE_W-1:0];
    end

    // previous polarised input, tracked always so enabling makes no edge
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw;
    end

    // prescaler: counts source enables in time mode, cleared when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !en || mode)
            pre_cnt <= '0;
        else if (src)
            pre_cnt <= (pre_cnt == pre_lim) ? '0 : pre_cnt + 1'b1;
    end

    // glitch filter: level flips after filt_lim+1 differing samples in a row
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !mode) begin
            filt_lvl <= 1'b0;
            filt_run <= '0;
        end else if (src) begin
            if (raw == filt_lvl) begin
                filt_run <= '0;
            end else if (filt_run == filt_lim) begin
                filt_lvl <= raw;
                filt_run <= '0;
            end else begin
                filt_run <= filt_run + 1'b1;
            end
        end
    end

    // count enable selection by mode and bypass
    always_comb begin
        if (!en)
            tick = 1'b0;
        else if (!mode)
            tick = bypass ? src : (src && pre_cnt == pre_lim);
        else
            tick = bypass ? (raw && !raw_q)
                          : (src && raw && !filt_lvl && filt_run == filt_lim);
    end
endmodule

// File: rtl/ltpc_core.sv
// Counter core: advances the count on each tick, detects the compare match,
// emits the registered trigger and restarts or wraps. Assumes tick is a
// single-cycle enable; cleared whenever run is low.
module ltpc_core #(
    parameter int CW = ltpc_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          freerun,
    input  logic          tick,
    input  logic [CW-1:0] cmp,
    output logic [CW-1:0] cnt,
    output logic          trig,
    output logic          hit
);
    assign hit = en && tick && (cnt == cmp);

    // count register with match restart or natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (hit && !freerun)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // trigger pulse, one cycle per match
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= hit;
    end
endmodule

// File: rtl/ltpc_top.sv
// Top of the low-power timer / pulse counter: connects register file, tick
// generator and counter core. All sources are enables in the clk domain.
module ltpc_top
    import ltpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    localparam int NSRC  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-1:0]   pin_in,
    output logic              trig_o,
    output logic              irq_o
);
    ctrl_t            ctrl;
    pre_t             pre;
    logic [CNT_W-1:0] cmp, cnt;
    logic             flag, hit, tick;

    ltpc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .hit(hit), .cnt(cnt), .ctrl(ctrl), .pre(pre),
        .cmp(cmp), .flag(flag), .bus_rdata(bus_rdata)
    );

    ltpc_tick_gen #(.SW(SEL_W), .CWD(CODE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .mode(ctrl.mode),
        .pol(ctrl.pol), .pin(ctrl.pin), .bypass(pre.bypass),
        .clksel(pre.clksel), .code(pre.code), .src_en(src_en),
        .pin_in(pin_in), .tick(tick)
    );

    ltpc_core #(.CW(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .freerun(ctrl.freerun),
        .tick(tick), .cmp(cmp), .cnt(cnt), .trig(trig_o), .hit(hit)
    );

    assign irq_o = flag && ctrl.ie;
endmodule

// File: rtl/ltpc_chk.sv
// Checker for ltpc_top: temporal properties over run state, flag, trigger,
// interrupt and count. Bound into the top below.
module ltpc_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          freerun,
    input logic          ie,
    input logic          flag,
    input logic          trig,
    input logic          irq,
    input logic          tick,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] cmp
);
    AST_TRIG_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) trig |-> flag); // R6
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !freerun && $past(en) && $stable(cmp) && $past(cnt <= cmp)) |-> (cnt <= cmp)); // R6
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !flag)); // R10
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n) !ie |-> !irq); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !flag |-> !irq); // R8
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(tick)) |-> (cnt == $past(cnt))); // R1
endmodule

bind ltpc_top ltpc_chk #(.CW(ltpc_pkg::CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .freerun(ctrl.freerun),
    .ie(ctrl.ie), .flag(flag), .trig(trig_o), .irq(irq_o), .tick(tick),
    .cnt(cnt), .cmp(cmp)
);

// File: tb/sim_ltpc_top.sv
module sim_ltpc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_en = '0;
    logic [3:0]  pin_in = '0;
    logic        trig_o, irq_o;
    int          n_chk = 0;
    int          n_err = 0;
    int          trig_seen = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ltpc_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_en(src_en),
        .pin_in(pin_in), .trig_o(trig_o), .irq_o(irq_o)
    );

    always @(negedge clk) if (trig_o) trig_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic get_cnt(output logic [31:0] d);
        wr(4'hC, 32'h0);
        rd(4'hC, d);
    endtask

    function automatic logic [31:0] csr(bit en, bit mode, bit fr, bit pol,
                                        int pin, bit ie, bit clr);
        return {24'h0, clr, ie, 2'(pin), pol, fr, mode, en};
    endfunction

    function automatic logic [31:0] prew(int sel, bit byp, int code);
        return {25'h0, 4'(code), byp, 2'(sel)};
    endfunction

    function automatic int exp_cnt(int k, int c, bit fr);
        return fr ? (k % 65536) : (k % (c + 1));
    endfunction

    function automatic int exp_hits(int k, int c, bit fr);
        if (!fr) return k / (c + 1);
        if (k < c + 1) return 0;
        return 1 + (k - (c + 1)) / 65536;
    endfunction

    task automatic run_src(input int sel, input int n);
        repeat (n) begin
            @(negedge clk);
            src_en[sel] = 1'b1;
        end
        @(negedge clk);
        src_en = '0;
    endtask

    task automatic drive_pin(input int p, input bit lvl, input int n);
        @(negedge clk);
        pin_in[p] = lvl;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int t0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset values
        rd(4'h0, v); chk("R12 csr", v, 32'h00);
        rd(4'h4, v); chk("R12 pre", v, 32'h05);
        rd(4'h8, v); chk("R12 cmp", v, 32'h0);
        rd(4'hC, v); chk("R12 snap", v, 32'h0);
        chk("R12 irq", {31'h0, irq_o}, 32'h0);

        // R1 / R6 random compare trials, bypassed time mode on source 1
        for (int i = 0; i < 12; i++) begin
            int c = $urandom_range(0, 12);
            int k = $urandom_range(0, 40);
            bit fr = 1'($urandom_range(0, 1));
            wr(4'h0, 32'h0);
            wr(4'h4, prew(1, 1, 0));
            wr(4'h8, c);
            t0 = trig_seen;
            wr(4'h0, csr(1, 0, fr, 0, 0, 0, 0));
            run_src(1, k);
            get_cnt(v); chk("R1 count", v, exp_cnt(k, c, fr));
            rd(4'h0, v); chk("R6 flag", {31'h0, v[7]}, (exp_hits(k, c, fr) > 0) ? 1 : 0);
            chk("R6 trig pulses", trig_seen - t0, exp_hits(k, c, fr));
        end

        // R7 free-run wrap past 0xFFFF
        wr(4'h0, 32'h0);
        wr(4'h8, 32'd2);
        t0 = trig_seen;
        wr(4'h0, csr(1, 0, 1, 0, 0, 0, 0));
        run_src(1, 65536 + 5);
        get_cnt(v); chk("R7 wrap count", v, 32'd5);
        chk("R7 matches", trig_seen - t0, 32'd2);

        // R8 write-one-to-clear and interrupt
        wr(4'h0, csr(1, 0, 1, 0, 0, 1, 0));
        chk("R8 irq set", {31'h0, irq_o}, 32'h1);
        rd(4'h0, v); chk("R8 flag kept on zero write", {31'h0, v[7]}, 32'h1);
        wr(4'h0, csr(1, 0, 1, 0, 0, 1, 1));
        rd(4'h0, v); chk("R8 flag cleared", {31'h0, v[7]}, 32'h0);
        chk("R8 irq low", {31'h0, irq_o}, 32'h0);

        // R9 snapshot holds until the next latch
        get_cnt(v); chk("R9 snapshot", v, 32'd5);
        run_src(1, 3);
        rd(4'hC, v); chk("R9 held", v, 32'd5);
        get_cnt(v); chk("R9 relatch", v, 32'd8);

        // R11 setup locked while running
        wr(4'h4, prew(3, 0, 9));
        rd(4'h4, v); chk("R11 pre locked", v, 32'h05);
        wr(4'h0, csr(1, 1, 1, 1, 2, 0, 0));
        rd(4'h0, v); chk("R11 mode locked", v[5:0], 32'h05);

        // R10 stop clears count, flag and prescaler
        wr(4'h0, 32'h0);
        wr(4'h4, prew(1, 0, 1));
        wr(4'h0, csr(1, 0, 0, 0, 0, 0, 0));
        get_cnt(v); chk("R10 count cleared", v, 32'h0);
        run_src(1, 3);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R10 flag cleared", {31'h0, v[7]}, 32'h0);
        wr(4'h0, csr(1, 0, 0, 0, 0, 0, 0));
        run_src(1, 1);
        get_cnt(v); chk("R10 prescaler cleared", v, 32'h0);

        // R3 / R4 random prescale with a noise source
        for (int i = 0; i < 6; i++) begin
            int code = $urandom_range(0, 4);
            int sel = $urandom_range(0, 3);
            int s = $urandom_range(0, 150);
            wr(4'h0, 32'h0);
            wr(4'h4, prew(sel, 0, code));
            wr(4'h8, 32'hFFFF);
            wr(4'h0, csr(1, 0, 0, 0, 0, 0, 0));
            run_src((sel + 1) % 4, 40);
            get_cnt(v); chk("R4 other source ignored", v, 32'h0);
            run_src(sel, s);
            get_cnt(v); chk("R3 prescaled count", v, s >> (code + 1));
        end

        // R2 random pulse counting, bypass, polarity and pin select
        for (int i = 0; i < 8; i++) begin
            int p = $urandom_range(0, 3);
            bit pol = 1'($urandom_range(0, 1));
            int n = $urandom_range(0, 15);
            wr(4'h0, 32'h0);
            pin_in = pol ? 4'hF : 4'h0;
            wr(4'h4, prew(0, 1, 0));
            wr(4'h8, 32'hFFFF);
            wr(4'h0, csr(0, 1, 0, pol, p, 0, 0));
            wr(4'h0, csr(1, 1, 0, pol, p, 0, 0));
            for (int j = 0; j < 5; j++) begin
                drive_pin((p + 1) % 4, !pol, 1);
                drive_pin((p + 1) % 4, pol, 1);
            end
            for (int j = 0; j < n; j++) begin
                drive_pin(p, !pol, $urandom_range(1, 3));
                drive_pin(p, pol, $urandom_range(1, 2));
            end
            get_cnt(v); chk("R2 edge count", v, n);
        end
        pin_in = '0;

        // R5 glitch filter, code 2 needs four samples
        wr(4'h0, 32'h0);
        wr(4'h4, prew(0, 0, 2));
        wr(4'h0, csr(0, 1, 0, 0, 0, 0, 0));
        src_en = 4'h1;
        wr(4'h0, csr(1, 1, 0, 0, 0, 0, 0));
        drive_pin(0, 1, 3);
        drive_pin(0, 0, 8);
        get_cnt(v); chk("R5 short glitch rejected", v, 32'h0);
        drive_pin(0, 1, 4);
        drive_pin(0, 0, 8);
        get_cnt(v); chk("R5 stable pulse counted", v, 32'h1);

        // R5 code 0 behaves as two samples
        wr(4'h0, 32'h0);
        wr(4'h4, prew(0, 0, 0));
        wr(4'h0, csr(1, 1, 0, 0, 0, 0, 0));
        drive_pin(0, 1, 1);
        drive_pin(0, 0, 4);
        get_cnt(v); chk("R5 code0 one sample rejected", v, 32'h0);
        drive_pin(0, 1, 2);
        drive_pin(0, 0, 4);
        get_cnt(v); chk("R5 code0 two samples counted", v, 32'h1);
        src_en = '0;

        finish_run();
    end
endmodule